// File: doc/BRIEF.md
# SIMD Unpack and Duplicate Unit

This block rearranges 32-bit and 64-bit elements of two 256-bit vector operands, A and B. It handles interleaving and element duplication. A vector is split into two 128-bit lanes. Each operation is applied to each lane on its own, so no element ever crosses a lane boundary. A length flag selects 128-bit or 256-bit operation. In the 128-bit case only the low lane is computed, and the upper half of the result is cleared.

Operands are presented with `in_valid`. The result is registered and appears one clock later, qualified by `out_valid`. An opcode outside the defined set produces a zero result and raises `illegal` for that single output cycle. The unit is meant to sit in a vector execution pipeline as one register stage.

Top module: `simd_unpack_dup`

## Requirements
- R1: Opcode 0 (interleave low 32-bit) gives, per lane, elements {A0, B0, A1, B1}, where element 0 is the least significant 32 bits of the lane.
- R2: Opcode 1 (interleave high 32-bit) gives, per lane, elements {A2, B2, A3, B3}.
- R3: Opcode 2 gives, per lane, the 64-bit elements {A0, B0}. Opcode 3 gives, per lane, the 64-bit elements {A1, B1}.
- R4: Opcode 4 copies each even 64-bit element of B into the next odd position, giving per lane {B0, B0} in 64-bit elements.
- R5: Opcode 5 copies each even 32-bit element of B into the odd position above it, giving per lane {B0, B0, B2, B2}. Opcode 6 copies each odd 32-bit element of B into the even position below it, giving per lane {B1, B1, B3, B3}.
- R6: When `wide` is 0 (128-bit length), result bits 255:128 are zero.
- R7: When `wide` is 1, the upper lane applies the same pattern to operand bits 255:128.
- R8: The result and `out_valid` = 1 appear exactly one clock after a cycle with `in_valid` = 1. With `in_valid` = 0, the next cycle has `out_valid` = 0 and `result` holds its last value.
- R9: Opcode 7 gives an all-zero result, with `illegal` = 1 for exactly that one output cycle.
- R10: After reset, `out_valid`, `illegal` and `result` are all zero.
- R11: For opcodes 4, 5 and 6, the value of A has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 3 | Operation select (0 to 6 defined, 7 illegal) |
| wide | input | 1 | 1 = 256-bit length, 0 = 128-bit length |
| a | input | 256 | First operand |
| b | input | 256 | Second operand |
| out_valid | output | 1 | Result valid |
| result | output | 256 | Registered result |
| illegal | output | 1 | Undefined opcode was presented one cycle earlier |

## Verification
The unit holds only one result register and two flags. A fault therefore shows at the ports in the very next output cycle, as one of the following:
- a misplaced or stale element;
- a nonzero upper half at 128-bit length;
- a valid or illegal flag that is missing, or that lingers.

Operand elements carry their own source and index in their values. Any element taken from the wrong operand, position or lane is thus visible directly. The duplicate operations are repeated with a different A to show that A cannot reach the result.

// File: rtl/simd_unpack_dup.sv
module simd_unpack_dup #(
  parameter int LANE_W = 128,
  parameter int OP_W   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [OP_W-1:0]       op,
  input  logic                  wide,
  input  logic [2*LANE_W-1:0]   a,
  input  logic [2*LANE_W-1:0]   b,
  output logic                  out_valid,
  output logic [2*LANE_W-1:0]   result,
  output logic                  illegal
);

  localparam int VEC_W = 2 * LANE_W;
  localparam int LANES = VEC_W / LANE_W;
  localparam int DW    = LANE_W / 4;
  localparam int QW    = LANE_W / 2;

  localparam logic [OP_W-1:0] OP_ILO32 = OP_W'(0);
  localparam logic [OP_W-1:0] OP_IHI32 = OP_W'(1);
  localparam logic [OP_W-1:0] OP_ILO64 = OP_W'(2);
  localparam logic [OP_W-1:0] OP_IHI64 = OP_W'(3);
  localparam logic [OP_W-1:0] OP_DUP64 = OP_W'(4);
  localparam logic [OP_W-1:0] OP_DUPE  = OP_W'(5);
  localparam logic [OP_W-1:0] OP_DUPO  = OP_W'(6);

  logic [VEC_W-1:0] nxt;
  logic             op_bad;

  assign op_bad = op > OP_DUPO;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] la, lb, r;
    assign la = a[g*LANE_W +: LANE_W];
    assign lb = b[g*LANE_W +: LANE_W];

    always_comb begin
      case (op)
        OP_ILO32: r = {lb[1*DW +: DW], la[1*DW +: DW], lb[0 +: DW], la[0 +: DW]};
        OP_IHI32: r = {lb[3*DW +: DW], la[3*DW +: DW], lb[2*DW +: DW], la[2*DW +: DW]};
        OP_ILO64: r = {lb[0 +: QW], la[0 +: QW]};
        OP_IHI64: r = {lb[QW +: QW], la[QW +: QW]};
        OP_DUP64: r = {lb[0 +: QW], lb[0 +: QW]};
        OP_DUPE:  r = {lb[2*DW +: DW], lb[2*DW +: DW], lb[0 +: DW], lb[0 +: DW]};
        OP_DUPO:  r = {lb[3*DW +: DW], lb[3*DW +: DW], lb[1*DW +: DW], lb[1*DW +: DW]};
        default:  r = '0;
      endcase
    end

    if (g == 0) begin : g_low
      assign nxt[g*LANE_W +: LANE_W] = r;
    end else begin : g_up
      assign nxt[g*LANE_W +: LANE_W] = wide ? r : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      illegal   <= in_valid && op_bad;
      if (in_valid) result <= nxt;
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result));
  // R6
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !wide |=> result[VEC_W-1:LANE_W] == '0);
  // R9
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> out_valid && result == '0);
  // R9
  illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_bad |=> illegal);
  // R4
  dup64_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_DUP64 |=> result[QW-1:0] == result[LANE_W-1:QW]);
  // R5
  dup32_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op == OP_DUPE || op == OP_DUPO) |=> result[DW-1:0] == result[2*DW-1:DW]);

endmodule

// File: tb/simd_unpack_dup_tb.sv
`timescale 1ns/1ps
module simd_unpack_dup_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [2:0]   op = '0;
  logic         wide = 1'b0;
  logic [255:0] a = '0, b = '0;
  logic         out_valid, illegal;
  logic [255:0] result;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  simd_unpack_dup u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .wide(wide),
    .a(a), .b(b), .out_valid(out_valid), .result(result), .illegal(illegal)
  );

  // entry: op[68:66], wide[65], illegal[64], element codes[63:0] (byte k = element k)
  // code: high nibble A or B, low nibble element index; 00 = zero
  localparam logic [68:0] TBL [16] = '{
    {3'd0, 1'b1, 1'b0, 64'hB5A5B4A4_B1A1B0A0},
    {3'd0, 1'b0, 1'b0, 64'h00000000_B1A1B0A0},
    {3'd1, 1'b1, 1'b0, 64'hB7A7B6A6_B3A3B2A2},
    {3'd1, 1'b0, 1'b0, 64'h00000000_B3A3B2A2},
    {3'd2, 1'b1, 1'b0, 64'hB5B4A5A4_B1B0A1A0},
    {3'd2, 1'b0, 1'b0, 64'h00000000_B1B0A1A0},
    {3'd3, 1'b1, 1'b0, 64'hB7B6A7A6_B3B2A3A2},
    {3'd3, 1'b0, 1'b0, 64'h00000000_B3B2A3A2},
    {3'd4, 1'b1, 1'b0, 64'hB5B4B5B4_B1B0B1B0},
    {3'd4, 1'b0, 1'b0, 64'h00000000_B1B0B1B0},
    {3'd5, 1'b1, 1'b0, 64'hB6B6B4B4_B2B2B0B0},
    {3'd5, 1'b0, 1'b0, 64'h00000000_B2B2B0B0},
    {3'd6, 1'b1, 1'b0, 64'hB7B7B5B5_B3B3B1B1},
    {3'd6, 1'b0, 1'b0, 64'h00000000_B3B3B1B1},
    {3'd7, 1'b1, 1'b1, 64'h00000000_00000000},
    {3'd7, 1'b0, 1'b1, 64'h00000000_00000000}
  };

  function automatic logic [255:0] mk_op(logic [15:0] tag);
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = {tag, 16'(i)};
    return v;
  endfunction

  function automatic logic [255:0] expand(logic [63:0] codes, logic [15:0] ta, logic [15:0] tb);
    logic [255:0] v;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] c;
      c = codes[i*8 +: 8];
      if (c == 8'h00) v[i*32 +: 32] = '0;
      else v[i*32 +: 32] = {(c[7:4] == 4'hA) ? ta : tb, 12'h0, c[3:0]};
    end
    return v;
  endfunction

  function automatic string op_tag(logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd4: return "R4";
      3'd5, 3'd6: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] o, logic w, logic [255:0] va, logic [255:0] vb);
    @(negedge clk);
    op = o; wide = w; a = va; b = vb; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [255:0] last;
    repeat (3) @(negedge clk);
    // R10
    check("R10 out_valid", {255'b0, out_valid}, '0);
    check("R10 illegal", {255'b0, illegal}, '0);
    check("R10 result", result, '0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < 16; k++) begin
      logic [68:0] e;
      logic [255:0] exp;
      e = TBL[k];
      exp = expand(e[63:0], 16'hAAAA, 16'hBBBB);
      issue(e[68:66], e[65], mk_op(16'hAAAA), mk_op(16'hBBBB));
      check({op_tag(e[68:66]), e[65] ? " R7" : " R6"}, result, exp);
      check("R8 out_valid", {255'b0, out_valid}, 256'd1);
      check("R9 illegal", {255'b0, illegal}, {255'b0, e[64]});
      if (!e[65]) check("R6 upper zero", {128'b0, result[255:128]}, '0);
    end

    // R8: idle cycle keeps result, drops valid
    issue(3'd0, 1'b1, mk_op(16'hAAAA), mk_op(16'hBBBB));
    last = result;
    @(negedge clk);
    check("R8 idle valid", {255'b0, out_valid}, '0);
    check("R8 hold", result, last);

    // R9: illegal lasts exactly one cycle
    issue(3'd7, 1'b1, mk_op(16'hAAAA), mk_op(16'hBBBB));
    check("R9 pulse", {255'b0, illegal}, 256'd1);
    @(negedge clk);
    check("R9 one cycle", {255'b0, illegal}, '0);

    // R8: back-to-back operations
    @(negedge clk);
    op = 3'd1; wide = 1'b1; a = mk_op(16'hAAAA); b = mk_op(16'hBBBB); in_valid = 1'b1;
    @(negedge clk);
    check("R8 b2b first", result, expand(64'hB7A7B6A6_B3A3B2A2, 16'hAAAA, 16'hBBBB));
    op = 3'd2; wide = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 b2b second", result, expand(64'h00000000_B1B0A1A0, 16'hAAAA, 16'hBBBB));
    check("R8 b2b valid", {255'b0, out_valid}, 256'd1);

    // R11: A has no effect on duplications
    issue(3'd4, 1'b1, ~mk_op(16'h1234), mk_op(16'hBBBB));
    check("R11 dup64", result, expand(64'hB5B4B5B4_B1B0B1B0, 16'hAAAA, 16'hBBBB));
    issue(3'd5, 1'b1, '1, mk_op(16'hBBBB));
    check("R11 dup even", result, expand(64'hB6B6B4B4_B2B2B0B0, 16'hAAAA, 16'hBBBB));
    issue(3'd6, 1'b1, '0, mk_op(16'hBBBB));
    check("R11 dup odd", result, expand(64'hB7B7B5B5_B3B3B1B1, 16'hAAAA, 16'hBBBB));

    // R7: upper lane uses only upper operand bits
    issue(3'd0, 1'b1, {mk_op(16'hAAAA)[255:128], 128'b0}, {mk_op(16'hBBBB)[255:128], 128'b0});
    check("R7 upper lane", result, {expand(64'hB5A5B4A4_00000000, 16'hAAAA, 16'hBBBB)[255:128], 128'b0});

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule